// File: doc/BRIEF.md
# SCSI Selection Monitor and Bus Status Registers

This block belongs to a SCSI bus controller and sits behind a small byte-wide processor register port. It samples the active-low SCSI control and data lines through a synchroniser chain and shows their live state, converted to active-high logic values, in a read-only status byte. The same address, when written, loads a mask of the SCSI IDs that this device answers to. When the bus shows a selection of a masked ID, the block latches an interrupt. Parity checking of the data bus during selection is optional and is enabled by a mode bit.

The block also holds a target command register whose low bits drive the bus phase lines (I/O, C/D, MSG, REQ) as active-low outputs. Two DMA status flags are kept. One marks that the final byte of a send was taken from the DMA controller. The other marks the later point at which that byte was actually placed on the SCSI data bus. Arbitration, the DMA engine itself and handshake sequencing are outside this block.

Register addresses: 2 is the mode register, 3 is the target command register, 4 is bus status on read and the ID mask on write, 5 is the controller status byte, and a read of 7 acknowledges the interrupt.

Top module: `scsi_sel_monitor`

## Requirements
- R1: A read of address 4 returns the synchronised bus lines as active-high values (1 = pin driven low). The bit order from bit 7 down to bit 0 is RST, BSY, REQ, MSG, C/D, I/O, SEL, DBP. A pin change that is set up before clock edge k is still invisible after edge k and becomes visible after edge k+1.
- R2: A write to address 4 loads the 8-bit ID mask (bit n = SCSI ID n). A later read of address 4 still returns bus status and never returns the mask.
- R3: The interrupt output irq_o sets on the first clock at which the synchronised bus shows all of the following together: SEL asserted, BSY deasserted, and a data bit asserted whose mask bit is 1. A non-matching ID or an asserted BSY sets nothing.
- R4: With the ID mask all zeros, no bus activity sets the interrupt.
- R5: The interrupt stays set until a read of address 7 clears it. While the selection condition is still held it does not set again. It sets again once the condition has dropped and returned.
- R6: Bit 5 of the mode register (address 2) enables parity checking. Parity is odd over the eight data bits plus DBP, all taken as active-high values. When a selection sets the interrupt with checking enabled and parity bad, bit 5 of address 5 sets. The interrupt still fires. Without the enable the bit stays clear. A read of address 7 clears the bit.
- R7: Address 3 bits 0, 1, 2 and 3 hold I/O, C/D, MSG and REQ and drive tgt_io_no, tgt_cd_no, tgt_msg_no and tgt_req_no low when set. On a read, bits 6:4 are zero. Bit 7 is the last-byte-sent flag and is not affected by writes.
- R8: Last-byte-sent (address 3 bit 7) sets on dma_on_bus_i and clears on dma_start_i. Start takes priority when both occur in the same cycle.
- R9: End-of-DMA (address 5 bit 7) sets on dma_taken_i and clears on dma_start_i. It is independent of last-byte-sent. Address 5 bit 4 mirrors the interrupt.
- R10: After reset all registers read as zero, irq_o is low and all phase outputs are high (deasserted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register port select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, zero when no read is selected |
| bus_db_ni | input | 8 | SCSI data lines, active low |
| bus_dbp_ni | input | 1 | SCSI data parity line, active low |
| bus_rst_ni | input | 1 | SCSI RST line, active low |
| bus_bsy_ni | input | 1 | SCSI BSY line, active low |
| bus_req_ni | input | 1 | SCSI REQ line, active low |
| bus_msg_ni | input | 1 | SCSI MSG line, active low |
| bus_cd_ni | input | 1 | SCSI C/D line, active low |
| bus_io_ni | input | 1 | SCSI I/O line, active low |
| bus_sel_ni | input | 1 | SCSI SEL line, active low |
| tgt_io_no | output | 1 | Driven I/O phase line, active low |
| tgt_cd_no | output | 1 | Driven C/D phase line, active low |
| tgt_msg_no | output | 1 | Driven MSG phase line, active low |
| tgt_req_no | output | 1 | Driven REQ line, active low |
| dma_start_i | input | 1 | Pulse: a new DMA send begins |
| dma_taken_i | input | 1 | Pulse: last byte taken from the DMA controller |
| dma_on_bus_i | input | 1 | Pulse: last byte placed on the SCSI data bus |
| irq_o | output | 1 | Selection interrupt |

## Verification
The assertions check on every cycle that an interrupt only rises after a masked selection with BSY clear and a non-zero mask, and that it holds until the acknowledge read. They also check that a parity flag only rises with checking enabled and bad parity, that a DMA start leaves last-byte-sent clear, that end-of-DMA only rises after the taken pulse, and that phase outputs follow the written command bits. Only the bench scenarios can show the two-edge synchroniser latency and the exact status bit order. The same holds for the fact that the mask is unreadable, that the interrupt does not re-fire on a held selection but does re-fire after the condition drops, and that the two DMA flags separate in time.

// File: rtl/scsi_mon_pkg.sv
package scsi_mon_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CTL_W  = 8;
  localparam int unsigned BUS_W  = CTL_W + DATA_W;

  localparam logic [ADDR_W-1:0] A_MODE   = 3'd2;
  localparam logic [ADDR_W-1:0] A_TCMD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_BUS    = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;
  localparam logic [ADDR_W-1:0] A_IRQACK = 3'd7;

  localparam int unsigned MODE_PAR_BIT = 5;

  // order is the status byte layout, bit 7 first
  typedef struct packed {
    logic rst;
    logic bsy;
    logic req;
    logic msg;
    logic cd;
    logic io;
    logic sel;
    logic dbp;
  } bus_ctl_t;

  typedef struct packed {
    logic req;
    logic msg;
    logic cd;
    logic io;
  } phase_t;
endpackage

// File: rtl/scsi_bus_sync.sv
module scsi_bus_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/scsi_sel_detect.sv
module scsi_sel_detect #(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] db_i,
  input  logic            dbp_i,
  input  logic            bsy_i,
  input  logic            sel_i,
  input  logic [ID_W-1:0] mask_i,
  input  logic            par_en_i,
  input  logic            clr_i,
  output logic            irq_o,
  output logic            par_err_o
);
  logic cond, cond_q, hit, par_ok;

  assign cond   = (|(mask_i & db_i)) & sel_i & ~bsy_i;
  assign hit    = cond & ~cond_q;
  assign par_ok = ^{db_i, dbp_i};  // odd parity over data + parity bit

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q    <= 1'b0;
      irq_o     <= 1'b0;
      par_err_o <= 1'b0;
    end else begin
      cond_q <= cond;
      if (hit)        irq_o <= 1'b1;
      else if (clr_i) irq_o <= 1'b0;
      if (hit && par_en_i && !par_ok) par_err_o <= 1'b1;
      else if (clr_i)                 par_err_o <= 1'b0;
    end
  end

  a_r3_irq_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(sel_i && !bsy_i && ((mask_i & db_i) != '0)));
  a_r4_zero_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(mask_i) != '0);
  a_r5_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  a_r6_perr_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(par_err_o) |-> $past(par_en_i && !(^{db_i, dbp_i})));
endmodule

// File: rtl/scsi_dma_flags.sv
module scsi_dma_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic taken_i,
  input  logic on_bus_i,
  output logic eod_o,
  output logic lbs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eod_o <= 1'b0;
      lbs_o <= 1'b0;
    end else begin
      if (start_i)      eod_o <= 1'b0;
      else if (taken_i) eod_o <= 1'b1;
      if (start_i)       lbs_o <= 1'b0;
      else if (on_bus_i) lbs_o <= 1'b1;
    end
  end

  a_r8_start_clears_lbs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !lbs_o);
  a_r9_eod_after_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eod_o) |-> $past(taken_i));
endmodule

// File: rtl/scsi_sel_monitor.sv
module scsi_sel_monitor
  import scsi_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] bus_db_ni,
  input  logic              bus_dbp_ni,
  input  logic              bus_rst_ni,
  input  logic              bus_bsy_ni,
  input  logic              bus_req_ni,
  input  logic              bus_msg_ni,
  input  logic              bus_cd_ni,
  input  logic              bus_io_ni,
  input  logic              bus_sel_ni,
  output logic              tgt_io_no,
  output logic              tgt_cd_no,
  output logic              tgt_msg_no,
  output logic              tgt_req_no,
  input  logic              dma_start_i,
  input  logic              dma_taken_i,
  input  logic              dma_on_bus_i,
  output logic              irq_o
);
  bus_ctl_t          ctl_raw, ctl_s;
  logic [DATA_W-1:0] db_s;
  logic [BUS_W-1:0]  bus_s;

  logic [DATA_W-1:0] mode_q, mask_q;
  phase_t            tcmd_q;
  logic              wr_en, rd_en, irq_ack, par_err, eod, lbs;

  assign ctl_raw = bus_ctl_t'(~{bus_rst_ni, bus_bsy_ni, bus_req_ni, bus_msg_ni,
                                bus_cd_ni, bus_io_ni, bus_sel_ni, bus_dbp_ni});

  scsi_bus_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ctl_raw, ~bus_db_ni}),
    .q_o   (bus_s)
  );
  assign ctl_s = bus_ctl_t'(bus_s[BUS_W-1:DATA_W]);
  assign db_s  = bus_s[DATA_W-1:0];

  assign wr_en   = cs_i & wr_i;
  assign rd_en   = cs_i & rd_i;
  assign irq_ack = rd_en & (addr_i == A_IRQACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      mask_q <= '0;
      tcmd_q <= '0;
    end else if (wr_en) begin
      unique case (addr_i)
        A_MODE:  mode_q <= wdata_i;
        A_BUS:   mask_q <= wdata_i;
        A_TCMD:  tcmd_q <= phase_t'(wdata_i[3:0]);
        default: ;
      endcase
    end
  end

  scsi_sel_detect #(.ID_W(DATA_W)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .db_i     (db_s),
    .dbp_i    (ctl_s.dbp),
    .bsy_i    (ctl_s.bsy),
    .sel_i    (ctl_s.sel),
    .mask_i   (mask_q),
    .par_en_i (mode_q[MODE_PAR_BIT]),
    .clr_i    (irq_ack),
    .irq_o    (irq_o),
    .par_err_o(par_err)
  );

  scsi_dma_flags u_dma (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (dma_start_i),
    .taken_i (dma_taken_i),
    .on_bus_i(dma_on_bus_i),
    .eod_o   (eod),
    .lbs_o   (lbs)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      case (addr_i)
        A_MODE:  rdata_o = mode_q;
        A_TCMD:  rdata_o = {lbs, 3'b000, tcmd_q};
        A_BUS:   rdata_o = ctl_s;
        A_STAT:  rdata_o = {eod, 1'b0, par_err, irq_o, 4'b0000};
        default: rdata_o = '0;
      endcase
    end
  end

  assign tgt_io_no  = ~tcmd_q.io;
  assign tgt_cd_no  = ~tcmd_q.cd;
  assign tgt_msg_no = ~tcmd_q.msg;
  assign tgt_req_no = ~tcmd_q.req;

  a_r7_req_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i == A_TCMD) |=> tgt_req_no == !$past(wdata_i[3]));
  a_r7_io_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && addr_i == A_TCMD) |=> tgt_io_no == !$past(wdata_i[0]));
endmodule

// File: tb/scsi_sel_monitor_test.sv
module scsi_sel_monitor_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 0, wr = 0, rd = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] db_n = 8'hFF;
  logic dbp_n = 1, brst_n = 1, bsy_n = 1, req_n = 1, msg_n = 1, cd_n = 1, io_n = 1, sel_n = 1;
  logic t_io_n, t_cd_n, t_msg_n, t_req_n, irq;
  logic dma_start = 0, dma_taken = 0, dma_on_bus = 0;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_sel_monitor uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .bus_db_ni(db_n), .bus_dbp_ni(dbp_n), .bus_rst_ni(brst_n), .bus_bsy_ni(bsy_n),
    .bus_req_ni(req_n), .bus_msg_ni(msg_n), .bus_cd_ni(cd_n), .bus_io_ni(io_n),
    .bus_sel_ni(sel_n),
    .tgt_io_no(t_io_n), .tgt_cd_no(t_cd_n), .tgt_msg_no(t_msg_n), .tgt_req_no(t_req_n),
    .dma_start_i(dma_start), .dma_taken_i(dma_taken), .dma_on_bus_i(dma_on_bus),
    .irq_o(irq)
  );

  // reference model state
  logic [15:0] hist[$];
  logic [7:0] m_mode, m_mask;
  logic [3:0] m_cmd;
  logic m_irq, m_perr, m_prev, m_lbs, m_eod;

  function automatic logic [15:0] pins_now();
    return ~{brst_n, bsy_n, req_n, msg_n, cd_n, io_n, sel_n, dbp_n, db_n};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {16'h0, 16'h0};
      m_mode = 0; m_mask = 0; m_cmd = 0;
      m_irq = 0; m_perr = 0; m_prev = 0; m_lbs = 0; m_eod = 0;
    end else begin
      logic [15:0] s;
      logic cond, ack;
      s = hist[0];
      cond = ((m_mask & s[7:0]) != 0) && s[9] && !s[14];
      ack = cs && rd && addr == 3'd7;
      if (cond && !m_prev) begin
        m_irq = 1;
        if (m_mode[5] && (^s[8:0]) == 1'b0) m_perr = 1;
        else if (ack) m_perr = 0;
      end else if (ack) begin
        m_irq = 0;
        m_perr = 0;
      end
      m_prev = cond;
      if (cs && wr) begin
        if (addr == 3'd2) m_mode = wdata;
        if (addr == 3'd4) m_mask = wdata;
        if (addr == 3'd3) m_cmd = wdata[3:0];
      end
      if (dma_start) begin m_lbs = 0; m_eod = 0; end
      else begin
        if (dma_on_bus) m_lbs = 1;
        if (dma_taken) m_eod = 1;
      end
      hist.push_back(pins_now());
      void'(hist.pop_front());
    end
  end

  function automatic logic [7:0] m_read(logic [2:0] a);
    case (a)
      3'd2: return m_mode;
      3'd3: return {m_lbs, 3'b000, m_cmd};
      3'd4: return hist[0][15:8];
      3'd5: return {m_eod, 1'b0, m_perr, m_irq, 4'b0000};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk({7'b0, irq}, {7'b0, m_irq}, "R3/R5 irq vs model");
      chk({4'b0, t_req_n, t_msg_n, t_cd_n, t_io_n}, {4'b0, ~m_cmd[3], ~m_cmd[2], ~m_cmd[1], ~m_cmd[0]},
          "R7 phase outputs vs model");
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #1;
    chk(rdata, m_read(a), {tag, " (model)"});
    chk(rdata, exp, tag);
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_idle();
    @(negedge clk);
    db_n = 8'hFF; dbp_n = 1; brst_n = 1; bsy_n = 1; req_n = 1; msg_n = 1;
    cd_n = 1; io_n = 1; sel_n = 1;
  endtask

  task automatic sel_of(input logic [7:0] ids, input logic par_asserted);
    @(negedge clk);
    db_n = ~ids; dbp_n = ~par_asserted; bsy_n = 1; sel_n = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;

    // R10 reset state
    reg_rd(3'd2, 8'h00, "R10 mode after reset");
    reg_rd(3'd3, 8'h00, "R10 tcmd after reset");
    reg_rd(3'd4, 8'h00, "R10 status after reset");
    reg_rd(3'd5, 8'h00, "R10 ctrl status after reset");
    chk({irq, t_io_n, t_cd_n, t_msg_n, t_req_n, 3'b0}, 8'b0111_1000, "R10 outputs after reset");

    // R1 latency and bit order
    @(negedge clk); bsy_n = 0; io_n = 0;
    reg_rd(3'd4, 8'h00, "R1 status one edge after change");
    reg_rd(3'd4, 8'h44, "R1 status BSY+IO");
    @(negedge clk); brst_n = 0; req_n = 0; msg_n = 0; cd_n = 0; sel_n = 0; dbp_n = 0;
    idle(2);
    reg_rd(3'd4, 8'hFF, "R1 status all asserted");
    @(negedge clk); brst_n = 1; bsy_n = 1; io_n = 1; cd_n = 1; sel_n = 1;
    idle(2);
    reg_rd(3'd4, 8'h31, "R1 status REQ+MSG+DBP");

    // R2 mask write is not readable
    reg_wr(3'd4, 8'hA5);
    reg_rd(3'd4, 8'h31, "R2 read after mask write shows status");
    bus_idle();
    reg_wr(3'd4, 8'h00);

    // R3 selection of masked id
    reg_wr(3'd4, 8'h04);
    sel_of(8'h04, 1'b0);
    idle(4);
    chk({7'b0, irq}, 8'h01, "R3 irq after masked selection");
    reg_rd(3'd5, 8'h10, "R9 irq mirror in ctrl status");

    // R5 clear and no re-fire while held
    reg_rd(3'd7, 8'h00, "R5 ack read");
    idle(4);
    chk({7'b0, irq}, 8'h00, "R5 no re-fire while held");
    @(negedge clk); sel_n = 1;
    idle(3);
    @(negedge clk); sel_n = 0;
    idle(4);
    chk({7'b0, irq}, 8'h01, "R5 re-fire after condition returns");
    bus_idle();
    idle(3);
    reg_rd(3'd7, 8'h00, "R5 ack read 2");

    // R3 negatives: busy asserted, other id
    @(negedge clk); db_n = ~8'h04; bsy_n = 0; sel_n = 0;
    idle(4);
    chk({7'b0, irq}, 8'h00, "R3 no irq with BSY asserted");
    bus_idle();
    sel_of(8'h08, 1'b1);
    idle(4);
    chk({7'b0, irq}, 8'h00, "R3 no irq for unmasked id");
    bus_idle();

    // R4 zero mask
    reg_wr(3'd4, 8'h00);
    sel_of(8'hFF, 1'b1);
    idle(4);
    chk({7'b0, irq}, 8'h00, "R4 zero mask blocks irq");
    bus_idle();
    idle(3);

    // R6 parity
    reg_wr(3'd2, 8'h20);
    reg_wr(3'd4, 8'h04);
    sel_of(8'h04, 1'b1);  // two ones: even -> bad
    idle(4);
    chk({7'b0, irq}, 8'h01, "R6 irq despite bad parity");
    reg_rd(3'd5, 8'h30, "R6 parity error flag set");
    reg_rd(3'd7, 8'h00, "R6 ack read");
    reg_rd(3'd5, 8'h00, "R6 flags cleared by ack");
    bus_idle();
    idle(3);
    sel_of(8'h04, 1'b0);  // good parity
    idle(4);
    reg_rd(3'd5, 8'h10, "R6 good parity no flag");
    reg_rd(3'd7, 8'h00, "R6 ack read 2");
    bus_idle();
    idle(3);
    reg_wr(3'd2, 8'h00);
    sel_of(8'h04, 1'b1);
    idle(4);
    reg_rd(3'd5, 8'h10, "R6 bad parity ignored when disabled");
    reg_rd(3'd7, 8'h00, "R6 ack read 3");
    bus_idle();
    idle(3);

    // R7 target command
    reg_wr(3'd3, 8'hFF);
    reg_rd(3'd3, 8'h0F, "R7 tcmd read masks upper bits");
    chk({4'b0, t_req_n, t_msg_n, t_cd_n, t_io_n}, 8'h00, "R7 all phase lines asserted");
    reg_wr(3'd3, 8'h05);
    chk({4'b0, t_req_n, t_msg_n, t_cd_n, t_io_n}, 8'h0A, "R7 IO and MSG asserted");
    reg_rd(3'd3, 8'h05, "R7 tcmd readback");

    // R8/R9 DMA flags
    @(negedge clk); dma_taken = 1;
    @(negedge clk); dma_taken = 0;
    reg_rd(3'd5, 8'h80, "R9 end-of-dma set");
    reg_rd(3'd3, 8'h05, "R8 lbs still clear after taken");
    @(negedge clk); dma_on_bus = 1;
    @(negedge clk); dma_on_bus = 0;
    reg_rd(3'd3, 8'h85, "R8 lbs set on bus");
    reg_wr(3'd3, 8'h00);
    reg_rd(3'd3, 8'h80, "R7 write does not touch lbs");
    @(negedge clk); dma_start = 1;
    @(negedge clk); dma_start = 0;
    reg_rd(3'd3, 8'h00, "R8 lbs cleared by start");
    reg_rd(3'd5, 8'h00, "R9 eod cleared by start");
    @(negedge clk); dma_start = 1; dma_on_bus = 1;
    @(negedge clk); dma_start = 0; dma_on_bus = 0;
    reg_rd(3'd3, 8'h00, "R8 start beats on-bus");

    idle(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule